// File: doc/BRIEF.md
# Jack Sense Interrupt Controller

This block holds one 16-bit control and status word for two headphone or line jack detect inputs. Each input passes through a two-flop synchronizer. It can then be held back by a long qualification timer, so that the input counts as present only after it has stayed high for a set time. The qualified levels drive three audio routing enables: equalizer bypass, six-to-two down-mix and two-to-six spread. The word also carries a three-bit mute selector, which is passed straight to an output bus.

Each input can run in plain sense mode or in interrupt mode. In interrupt mode, every change of the qualified level sets a sticky flag for that input. Software clears a flag by writing 0 and can raise one by writing 1. The two flags are ORed onto a single interrupt line. Software reaches the word through a plain write strobe with write data, and reads it back on a read data bus.

Top module: `jsi_ctrl`

## Requirements
- R1: After reset the read word is 0000h and irq_o, eq_bypass_o, downmix_o, spread_o are low.
- R2: Read bits 2 and 3 report the synchronized level of jack_i[0] and jack_i[1], two clocks after the pin changes. Writes to these bits are ignored.
- R3: The flags sit in bits 0 (pin 0) and 1 (pin 1). Writing 1 to a flag sets it, writing 0 clears it, and a flag keeps its value when no write occurs.
- R4: irq_o is high exactly when at least one flag is set.
- R5: Bits 4 and 5 select the mode of pin 0 and pin 1. With a mode bit of 1, every rise or fall of that pin's qualified level sets its flag. With a mode bit of 0, pin activity never sets the flag.
- R6: When a pin change sets a flag in the same cycle that software writes 0 to that flag, the flag ends up set.
- R7: Bits 6 and 7 enable the timer for pin 0 and pin 1. With the timer enabled, a pin counts as active only after its synchronized level has stayed high for QUAL_MS*CLK_HZ/1000 clocks. The count restarts whenever the level goes low, and the pin becomes inactive as soon as the level is low.
- R8: eq_bypass_o is high when bit 8 is set and pin 0 is active, or when bit 9 is set and pin 1 is active.
- R9: downmix_o is high when bit 13 is set and pin 0 is active. Bit 14 is stored and read back but drives no output.
- R10: spread_o is high when bit 15 is set and both pins are active.
- R11: Bits 12:10 are stored, read back, and driven unchanged on mute_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jack_i | input | 2 | Asynchronous jack detect pins |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data |
| irq_o | output | 1 | Combined interrupt |
| eq_bypass_o | output | 1 | Equalizer bypass enable |
| downmix_o | output | 1 | Down-mix activate |
| spread_o | output | 1 | Spread activate |
| mute_sel_o | output | 3 | Mute selector field |

## Verification
The hardest case to reach is a software clear that lands in the same cycle as a hardware flag set. The bench counts clocks through the two synchronizer stages and the change detector. It then places the write strobe exactly on the clock where the detected edge updates the flag, and expects the flag to survive. The timer restart is covered in a similar way. A high pulse shorter than the qualification window is followed by a low gap and a second high level. The pin must stay inactive until a full window has passed after the gap.

// File: rtl/jsi_pkg.sv
package jsi_pkg;
  localparam int unsigned NUM_PINS = 2;

  typedef struct packed {
    logic       spread_en;
    logic [1:0] dm_en;
    logic [2:0] mute_sel;
    logic [1:0] eqb_en;
    logic [1:0] tmr_en;
    logic [1:0] mode;
    logic [1:0] state;
    logic [1:0] flag;
  } jsi_word_t;
endpackage

// File: rtl/jsi_qualify.sv
module jsi_qualify #(
  parameter int unsigned LIMIT       = 278,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tmr_en_i,
  output logic level_o,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign level_o = sync_q[SYNC_STAGES-1];

  // high-time counter, restarts on any low level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!level_o)       cnt_q <= '0;
    else if (cnt_q != CMAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = tmr_en_i ? (level_o && cnt_q == CMAX) : level_o;

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_o |=> cnt_q == '0 || cnt_q == CW'(1));
  a_r7_qual_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> level_o);
endmodule

// File: rtl/jsi_flag.sv
module jsi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  input  logic mode_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic qual_q, hw_set, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= 1'b0;
    else         qual_q <= qual_i;
  end

  assign hw_set = mode_i && (qual_i != qual_q);

  // hardware set wins over a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hw_set) flag_q <= 1'b1;
    else if (wr_i)   flag_q <= wbit_i;
  end

  assign flag_o = flag_q;

  a_r3_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !wr_i |=> flag_q);
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set |=> flag_q);
  a_r5_sense_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i && !wr_i && !flag_q |=> !flag_q);
endmodule

// File: rtl/jsi_ctrl.sv
module jsi_ctrl #(
  parameter int unsigned CLK_HZ      = 24_576_000,
  parameter int unsigned QUAL_MS     = 278,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  jack_i,
  input  logic        wr_en_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o,
  output logic        eq_bypass_o,
  output logic        downmix_o,
  output logic        spread_o,
  output logic [2:0]  mute_sel_o
);
  import jsi_pkg::*;

  localparam int unsigned LIMIT = (CLK_HZ / 1000) * QUAL_MS;

  jsi_word_t ctrl_q, wr_word, rd_word;
  logic [NUM_PINS-1:0] level, qual, flag;

  assign wr_word = jsi_word_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i) begin
      ctrl_q       <= wr_word;
      ctrl_q.state <= '0;
      ctrl_q.flag  <= '0;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    jsi_qualify #(.LIMIT(LIMIT), .SYNC_STAGES(SYNC_STAGES)) i_qual (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (jack_i[p]),
      .tmr_en_i (ctrl_q.tmr_en[p]),
      .level_o  (level[p]),
      .qual_o   (qual[p])
    );
    jsi_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .qual_i (qual[p]),
      .mode_i (ctrl_q.mode[p]),
      .wr_i   (wr_en_i),
      .wbit_i (wr_word.flag[p]),
      .flag_o (flag[p])
    );
  end

  always_comb begin
    rd_word       = ctrl_q;
    rd_word.state = level;
    rd_word.flag  = flag;
  end

  assign rdata_o     = rd_word;
  assign irq_o       = |flag;
  assign eq_bypass_o = |(ctrl_q.eqb_en & qual);
  assign downmix_o   = ctrl_q.dm_en[0] & qual[0];
  assign spread_o    = ctrl_q.spread_en & (&qual);
  assign mute_sel_o  = ctrl_q.mute_sel;

  a_r10_spread_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spread_o |-> rdata_o[3] && rdata_o[2]);
  a_r9_downmix_pin0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    downmix_o |-> rdata_o[2] && rdata_o[13]);
endmodule

// File: tb/test_jsi_ctrl.sv
module test_jsi_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LIMIT      = 278;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  jack = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, eqb, dmx, spr;
  logic [2:0]  mute;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jsi_ctrl #(.CLK_HZ(1000), .QUAL_MS(LIMIT)) i_jsi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .jack_i(jack), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .eq_bypass_o(eqb),
    .downmix_o(dmx), .spread_o(spr), .mute_sel_o(mute));

  // {ctrl word, pins, expected {eqb, dmx, spr}}
  localparam logic [20:0] VEC [9] = '{
    {16'h0100, 2'b01, 3'b100}, {16'h0100, 2'b10, 3'b000},
    {16'h0200, 2'b10, 3'b100}, {16'h2000, 2'b01, 3'b010},
    {16'h2000, 2'b10, 3'b000}, {16'h8000, 2'b11, 3'b001},
    {16'h8000, 2'b01, 3'b000}, {16'hA300, 2'b11, 3'b111},
    {16'h4000, 2'b11, 3'b000}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    chk("R1 word", rdata, 16'h0000);
    chk("R1 outs", {irq, eqb, dmx, spr}, 4'b0000);
    rst_n = 1'b1;
    wait_clk(2);

    // R8 R9 R10 table walk, sense mode, no timer
    foreach (VEC[i]) begin
      wr(VEC[i][20:5]);
      jack = VEC[i][4:3];
      wait_clk(4);
      chk("R8 R9 R10 outs", {eqb, dmx, spr}, VEC[i][2:0]);
      chk("R2 R11 readback", rdata, VEC[i][20:5] | {12'h0, VEC[i][4:3], 2'b00});
    end

    // R2: state bits ignore writes and follow pins
    jack = 2'b10;
    wr(16'h000C);
    chk("R2 readonly", rdata[3:2], 2'b10);
    // R5: sense mode, pin toggles raise nothing
    jack = 2'b01; wait_clk(4);
    chk("R5 sense no flag", {irq, rdata[1:0]}, 3'b000);
    // R11: mute field
    wr(16'h1400);
    chk("R11 mute", mute, 3'b101);
    // R3 R4: software set and clear
    wr(16'h0002);
    chk("R3 set", rdata[1:0], 2'b10);
    chk("R4 irq", irq, 1'b1);
    wait_clk(3);
    chk("R3 sticky", rdata[1:0], 2'b10);
    wr(16'h0000);
    chk("R3 clear", rdata[1:0], 2'b00);
    chk("R4 irq low", irq, 1'b0);

    // R5: interrupt mode, rise and fall
    jack = 2'b00; wait_clk(4);
    wr(16'h0030);
    jack = 2'b10; wait_clk(4);
    chk("R5 rise flag", rdata[1:0], 2'b10);
    wr(16'h0030);
    chk("R5 cleared", rdata[1:0], 2'b00);
    jack = 2'b00; wait_clk(4);
    chk("R5 fall flag", rdata[1:0], 2'b10);
    wr(16'h0030);

    // R6: clear lands on the cycle the pin edge sets the flag
    @(negedge clk); jack = 2'b01;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wdata = 16'h0030;
    @(negedge clk); wr_en = 1'b0;
    chk("R6 set wins", rdata[0], 1'b1);
    wr(16'h0030);
    jack = 2'b00; wait_clk(4);
    wr(16'h0000);

    // R7: qualification timer on pin 0
    wr(16'h0140);
    jack = 2'b01; wait_clk(150);
    jack = 2'b00; wait_clk(5);
    jack = 2'b01; wait_clk(200);
    chk("R7 restart not yet", eqb, 1'b0);
    wait_clk(LIMIT - 200 - 4);
    chk("R7 just before", eqb, 1'b0);
    wait_clk(8);
    chk("R7 qualified", eqb, 1'b1);
    jack = 2'b00; wait_clk(3);
    chk("R7 drop", eqb, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule